// File: doc/BRIEF.md
# Encoded Set/Clear Output Bank

This block holds fourteen registered output lines that a host changes through one 8-bit write-only register at address 0x17. Each byte written there carries two 4-bit codes: the low code names the line to drive high, the high code names the line to drive low. A code of zero does nothing and the all-ones code addresses every line, so a single write never needs to know the state of the other lines. This avoids the read-modify-write step that a plain data register needs.

Outputs are numbered 1 to 14. Output n is bit n-1 of the output vector. The vector changes only on the clock edge that accepts a write, so a line that a write leaves high is never pulled low for part of a cycle. The asynchronous active-low reset clears the bank. Its release is synchronized to the clock inside the block.

Top module: `setclr_bank`

## Requirements
- R1: While reset is low, and from then until the first accepted write, all 14 outputs are 0. Reset clears the bank at any time, including in the middle of operation.
- R2: A write is accepted when the strobe is high and the address equals 0x17 at a rising clock edge. Its effect is visible on the outputs right after that same edge. Writes are accepted from the third rising edge after reset is released.
- R3: A low-nibble code (data bits 3:0) from 1 to 14 sets output n = code to 1. A high-nibble code (data bits 7:4) from 1 to 14 clears output n = code to 0.
- R4: A nibble code of 0 makes that field take no action.
- R5: A nibble code of 0xF makes that field act on all 14 outputs.
- R6: When one write both sets and clears the same output, the output ends at 0. For example, 0xFF clears all outputs, and 0x4F sets every output except output 4.
- R7: An accepted write leaves every output that neither field names at its previous value.
- R8: A strobe with any address other than 0x17, or no strobe at all, leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_stb_i | input | 1 | Host write strobe |
| wr_addr_i | input | 8 | Host register address |
| wr_data_i | input | 8 | Host write data: bits 3:0 are the set code, bits 7:4 are the clear code |
| bank_q_o | output | 14 | Registered output lines. Bit n-1 is output n |

## Verification
Each single-index code is applied alone so that a wrong index mapping shows up as a wrong bit, and the none and all codes are applied to a bank that is half set, so each field is told apart from the other. Colliding writes (0xFF, 0x4F and same-index set with clear) separate clear precedence from set precedence. Writes to a neighbouring address and address matches without a strobe show whether the decode is complete. A long pseudo-random run over all byte values and mixed addresses checks that bits outside each write's reach hold their values.

// File: rtl/setclr_pkg.sv
package setclr_pkg;
  localparam int unsigned LINE_COUNT = 14;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned BUS_AW     = 8;
  localparam int unsigned BUS_DW     = 2 * CODE_W;
  localparam logic [BUS_AW-1:0] CTRL_ADDR = 8'h17;
endpackage

// File: rtl/setclr_rst_sync.sv
module setclr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/setclr_code_dec.sv
module setclr_code_dec #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned LINES  = 14
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [LINES-1:0]  mask_o
);
  localparam logic [CODE_W-1:0] ALL_CODE = {CODE_W{1'b1}};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign mask_o[i] = (code_i == ALL_CODE) || (code_i == CODE_W'(i + 1));
  end

  always_comb begin
    if (!$isunknown(code_i)) begin
      // R4: the null code selects nothing
      assert_null_code_R4: assert (code_i != '0 || mask_o == '0);
      // R5: the all code selects every line
      assert_all_code_R5: assert (code_i != ALL_CODE || &mask_o);
      // R3: an index code selects at most one line
      assert_single_index_R3: assert (code_i == ALL_CODE || $onehot0(mask_o));
    end
  end
endmodule

// File: rtl/setclr_reg.sv
module setclr_reg #(
  parameter int unsigned LINES = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LINES-1:0] set_mask_i,
  input  logic [LINES-1:0] clr_mask_i,
  output logic [LINES-1:0] q_o
);
  logic [LINES-1:0] q_r;
  logic [LINES-1:0] q_nxt;

  always_comb begin
    q_nxt = (q_r | set_mask_i) & ~clr_mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_r <= '0;
    else if (load_i) q_r <= q_nxt;
  end

  assign q_o = q_r;

  // R6: lines named by the clear field are low after the write
  assert_clear_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ((q_r & $past(clr_mask_i)) == '0));
  // R3: lines set and not cleared are high after the write
  assert_set_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ((q_r & $past(set_mask_i & ~clr_mask_i)) == $past(set_mask_i & ~clr_mask_i)));
  // R7: lines outside both fields keep their value
  assert_untouched_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ((q_r & ~$past(set_mask_i | clr_mask_i)) == ($past(q_r) & ~$past(set_mask_i | clr_mask_i))));
endmodule

// File: rtl/setclr_bank.sv
module setclr_bank
  import setclr_pkg::*;
#(
  parameter int unsigned       LINES     = LINE_COUNT,
  parameter int unsigned       CW        = CODE_W,
  parameter int unsigned       AW        = BUS_AW,
  parameter logic [AW-1:0]     REG_ADDR  = CTRL_ADDR,
  parameter int unsigned       SYNC_STGS = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_stb_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [2*CW-1:0] wr_data_i,
  output logic [LINES-1:0] bank_q_o
);
  localparam int unsigned DW = 2 * CW;

  logic             rst_sync_n;
  logic             hit;
  logic [CW-1:0]    set_code;
  logic [CW-1:0]    clr_code;
  logic [LINES-1:0] set_mask;
  logic [LINES-1:0] clr_mask;

  setclr_rst_sync #(.STAGES(SYNC_STGS)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  always_comb begin
    hit      = wr_stb_i && (wr_addr_i == REG_ADDR);
    set_code = wr_data_i[CW-1:0];
    clr_code = wr_data_i[DW-1:CW];
  end

  setclr_code_dec #(.CODE_W(CW), .LINES(LINES)) u_set_dec (
    .code_i (set_code),
    .mask_o (set_mask)
  );

  setclr_code_dec #(.CODE_W(CW), .LINES(LINES)) u_clr_dec (
    .code_i (clr_code),
    .mask_o (clr_mask)
  );

  setclr_reg #(.LINES(LINES)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .load_i     (hit),
    .set_mask_i (set_mask),
    .clr_mask_i (clr_mask),
    .q_o        (bank_q_o)
  );

  // R8: no accepted write, no change
  assert_idle_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(wr_stb_i && wr_addr_i == REG_ADDR) |=> $stable(bank_q_o));
  // R1: reset holds the bank at zero
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (bank_q_o == '0));
endmodule

// File: tb/test_setclr_bank.sv
module test_setclr_bank;
  localparam int N = 14;

  logic         clk;
  logic         rst_n;
  logic         stb;
  logic [7:0]   addr;
  logic [7:0]   data;
  logic [N-1:0] q;

  int unsigned n_checks;
  int unsigned n_fail;
  logic [N-1:0] model;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  bit           done;

  setclr_bank i_setclr_bank (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_stb_i  (stb),
    .wr_addr_i (addr),
    .wr_data_i (data),
    .bank_q_o  (q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic [N-1:0] got, input logic [N-1:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %04h expected %04h", tag, got, exp);
    end
  endtask

  function automatic logic [N-1:0] apply(input logic [N-1:0] cur, input logic [7:0] d);
    logic [N-1:0] r;
    r = cur;
    for (int i = 0; i < N; i++) begin
      if (d[3:0] == 4'hF || int'(d[3:0]) == i + 1) r[i] = 1'b1;
    end
    for (int i = 0; i < N; i++) begin
      if (d[7:4] == 4'hF || int'(d[7:4]) == i + 1) r[i] = 1'b0;
    end
    return r;
  endfunction

  // driver: one bus cycle, expected result pushed to the scoreboard
  task automatic drive(input logic s, input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    stb = s; addr = a; data = d;
    if (s && a == 8'h17) model = apply(model, d);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    drive(1'b1, 8'h17, d, tag);
  endtask

  // monitor: compare just after each edge
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [N-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      #2;
      check(q, e, t);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; stb = 1'b0; addr = '0; data = '0;
    #1;
    check(q, '0, "R1 async clear");
    model = '0;
    repeat (2) @(negedge clk);
    check(q, '0, "R1 held in reset");
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(q, '0, "R1 after release");
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; stb = 1'b0; addr = '0; data = '0; model = '0;
    do_reset();

    wr(8'h00, "R4 null both");
    wr(8'h06, "R3 set 6");
    wr(8'h0D, "R3 set 13");
    wr(8'h60, "R3 clr 6 R7 keep 13");
    wr(8'hD3, "R3 clr 13 set 3");
    wr(8'h01, "R3 set 1");
    wr(8'h0E, "R3 set 14");
    wr(8'h10, "R3 clr 1");
    wr(8'h0F, "R5 set all");
    wr(8'hE0, "R3 clr 14");
    wr(8'h0A, "R4 null clr");
    wr(8'hF0, "R5 clr all");
    wr(8'h50, "R4 null set");
    wr(8'h0F, "R5 set all again");
    wr(8'hFF, "R6 all vs all");
    wr(8'h4F, "R6 all but 4");
    wr(8'h77, "R6 same index");
    wr(8'h70, "R7 clr 7 only");
    drive(1'b1, 8'h16, 8'hF0, "R8 wrong addr low");
    drive(1'b1, 8'h97, 8'hF0, "R8 wrong addr high bit");
    drive(1'b0, 8'h17, 8'hF0, "R8 no strobe");
    wr(8'h2F, "R2 back to back a");
    wr(8'h93, "R2 back to back b");

    begin
      logic [7:0] lfsr;
      lfsr = 8'hA5;
      for (int k = 0; k < 300; k++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (lfsr[0] && lfsr[2])
          drive(1'b1, lfsr ^ 8'h3C, lfsr, "R8 random addr");
        else if (lfsr[1] && lfsr[6])
          drive(1'b0, 8'h17, lfsr, "R8 random idle");
        else
          wr(lfsr, "R7 random write");
      end
    end

    repeat (2) @(negedge clk);
    do_reset();
    wr(8'h09, "R3 set 9 after reset");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule